// File: doc/BRIEF.md
# Hybrid crossbar and shared-bus allocator

This block decides, each clock, who may move data across a small on-chip fabric built from two different media. A set of master-only ports sits on a crossbar whose outputs lead to crossbar-attached IPs. A second set of IPs shares one global bus, and each of them can start transfers (as a master) or receive them (as a slave). The allocator takes a request line, a target ID, a write-data word and a one-cycle done strobe from every requester. It grants crossbar paths and bus ownership, and it drives the selects and data of every crossbar output and of the bus.

Crossbar transfers that do not collide on an output run side by side and never involve the bus. A crossbar master that addresses a bus IP passes through one extra crossbar output, the bridge. The bridge then competes for the bus as one more round-robin requester. The master is granted only when it holds both the bridge and the bus. A held path is never taken away before its owner pulses done. A request to an ID that maps to nothing is never granted and sets a sticky per-requester error bit.

Top module: `hxb_top`

## Requirements
- R1: After a synchronous reset, every grant, every crossbar output valid, bus_valid and every error bit is low.
- R2: Crossbar masters that request different crossbar outputs are all granted in the same cycle, one clock after their requests are first seen with the outputs free.
- R3: When several masters request one crossbar output, the winner is the first requester found at or after that output's pointer. The pointer resets to 0, and after a release it moves to the index just past the releasing owner. The bus uses the same rule over its requesters.
- R4: A granted owner keeps its crossbar output or the bus until it pulses done, and no other requester is granted it meanwhile. The resource is free one clock after done, and a waiting requester is granted one clock after that.
- R5: The bus has at most one owner at a time. Its requesters are bus masters 0..NB-1 plus the bridge at index NB.
- R6: A crossbar-to-crossbar transfer is granted even while the bus is owned by someone else.
- R7: A crossbar master targeting a bus IP is granted only while it owns the bridge and the bridge owns the bus. On an idle fabric, the grant appears two clocks after the request.
- R8: Target IDs 0..NXS-1 select crossbar outputs and IDs NXS..NXS+NB-1 select bus IPs. A crossbar master may use any of these IDs. A bus master may use only the bus IP IDs.
- R9: A request whose target ID is not allowed by R8 is never granted. It sets that requester's error bit one clock later. The bit stays set until the requester's clear input is pulsed while the bad request is no longer present.
- R10: While an output is owned, xs_src gives the owning master index and xs_data gives its write data. While the bus is owned, bus_sel gives target ID minus NXS and bus_data gives the owner's write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xm_req | input | NXM | Crossbar master request, held until done |
| xm_tgt | input | NXM*TW | Crossbar master target IDs |
| xm_wdata | input | NXM*DW | Crossbar master write data |
| xm_done | input | NXM | One-cycle end-of-transfer strobe |
| xm_err_clr | input | NXM | Clears the crossbar master error bits |
| xm_gnt | output | NXM | Crossbar master grants |
| xm_err | output | NXM | Sticky unmapped-target error |
| bm_req | input | NB | Bus master request, held until done |
| bm_tgt | input | NB*TW | Bus master target IDs |
| bm_wdata | input | NB*DW | Bus master write data |
| bm_done | input | NB | One-cycle end-of-transfer strobe |
| bm_err_clr | input | NB | Clears the bus master error bits |
| bm_gnt | output | NB | Bus ownership grants |
| bm_err | output | NB | Sticky illegal-target error |
| xs_valid | output | NXS | Crossbar output owned |
| xs_src | output | NXS*MW | Owning master index per crossbar output |
| xs_data | output | NXS*DW | Data per crossbar output |
| bus_valid | output | 1 | Bus owned |
| bus_sel | output | BSW | Addressed bus IP index |
| bus_data | output | DW | Data on the bus |

## Verification
The hardest case to reach is a crossbar master that wins the bridge while a bus master still holds the bus. A crossbar-to-crossbar transfer must then go ahead in parallel, and the bridge must take the bus exactly two clocks after the bus master's done. The directed stimulus sets this up deliberately: a bus master is granted first, and then one master aims at a bus IP while another aims at a crossbar output. A pseudo-random traffic phase with random hold times also tracks exclusivity on every output and on the bus. In that phase the bench measures each requester's longest wait against a fixed bound.

// File: rtl/hxb_pkg.sv
package hxb_pkg;
  function automatic int hxb_idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/hxb_rr_lock.sv
module hxb_rr_lock #(
  parameter int N = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [N-1:0]                      req,
  input  logic [N-1:0]                      rel,
  output logic                              busy,
  output logic [hxb_pkg::hxb_idx_w(N)-1:0]  owner
);
  localparam int IW = hxb_pkg::hxb_idx_w(N);

  logic [IW-1:0] ptr;
  logic [IW-1:0] pick;
  logic          found;

  // first requester at or after the pointer, wrapping
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!found && req[(int'(ptr) + k) % N]) begin
        found = 1'b1;
        pick  = IW'((int'(ptr) + k) % N);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      owner <= '0;
      ptr   <= '0;
    end else if (busy) begin
      if (rel[owner]) begin
        busy <= 1'b0;
        ptr  <= IW'((int'(owner) + 1) % N);
      end
    end else if (found) begin
      busy  <= 1'b1;
      owner <= pick;
    end
  end

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !rel[owner]) |=> (busy && $stable(owner)));
  p_free_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && rel[owner]) |=> !busy);
  p_take_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && |req) |=> busy);
endmodule

// File: rtl/hxb_top.sv
module hxb_top #(
  parameter int NXM = 3,
  parameter int NXS = 2,
  parameter int NB  = 3,
  parameter int DW  = 8,
  parameter int TW  = 3,
  localparam int MW  = hxb_pkg::hxb_idx_w(NXM),
  localparam int BSW = hxb_pkg::hxb_idx_w(NB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NXM-1:0]    xm_req,
  input  logic [NXM*TW-1:0] xm_tgt,
  input  logic [NXM*DW-1:0] xm_wdata,
  input  logic [NXM-1:0]    xm_done,
  input  logic [NXM-1:0]    xm_err_clr,
  output logic [NXM-1:0]    xm_gnt,
  output logic [NXM-1:0]    xm_err,
  input  logic [NB-1:0]     bm_req,
  input  logic [NB*TW-1:0]  bm_tgt,
  input  logic [NB*DW-1:0]  bm_wdata,
  input  logic [NB-1:0]     bm_done,
  input  logic [NB-1:0]     bm_err_clr,
  output logic [NB-1:0]     bm_gnt,
  output logic [NB-1:0]     bm_err,
  output logic [NXS-1:0]    xs_valid,
  output logic [NXS*MW-1:0] xs_src,
  output logic [NXS*DW-1:0] xs_data,
  output logic              bus_valid,
  output logic [BSW-1:0]    bus_sel,
  output logic [DW-1:0]     bus_data
);
  localparam int NT  = NXS + NB;
  localparam int DSW = hxb_pkg::hxb_idx_w(NXS + 1);
  localparam int BRW = hxb_pkg::hxb_idx_w(NB + 1);

  // target decode
  logic [NXM-1:0] xm_ok;
  logic [DSW-1:0] xm_dest [NXM];
  logic [NB-1:0]  bm_ok;

  always_comb begin
    for (int m = 0; m < NXM; m++) begin
      xm_ok[m]   = int'(xm_tgt[m*TW +: TW]) < NT;
      xm_dest[m] = (int'(xm_tgt[m*TW +: TW]) < NXS) ? DSW'(int'(xm_tgt[m*TW +: TW]))
                                                     : DSW'(NXS);
    end
    for (int i = 0; i < NB; i++) begin
      bm_ok[i] = (int'(bm_tgt[i*TW +: TW]) >= NXS) && (int'(bm_tgt[i*TW +: TW]) < NT);
    end
  end

  // one lock per crossbar output, index NXS is the bridge
  logic [NXS:0]   xb_busy;
  logic [MW-1:0]  xb_owner [NXS+1];

  for (genvar d = 0; d <= NXS; d++) begin : g_out
    logic [NXM-1:0] dreq;
    always_comb begin
      for (int m = 0; m < NXM; m++)
        dreq[m] = xm_req[m] && xm_ok[m] && (xm_dest[m] == DSW'(d));
    end
    hxb_rr_lock #(.N(NXM)) u_lock (
      .clk   (clk),
      .rst   (rst),
      .req   (dreq),
      .rel   (xm_done),
      .busy  (xb_busy[d]),
      .owner (xb_owner[d])
    );
  end

  // bus lock: bus masters plus the bridge at index NB
  logic            bus_busy;
  logic [BRW-1:0]  bus_owner;
  logic            bridge_rel;
  logic            bridge_on_bus;

  assign bridge_rel    = xb_busy[NXS] && xm_done[xb_owner[NXS]];
  assign bridge_on_bus = bus_busy && (bus_owner == BRW'(NB));

  hxb_rr_lock #(.N(NB + 1)) u_bus_lock (
    .clk   (clk),
    .rst   (rst),
    .req   ({xb_busy[NXS], bm_req & bm_ok}),
    .rel   ({bridge_rel, bm_done}),
    .busy  (bus_busy),
    .owner (bus_owner)
  );

  // grants and data paths
  always_comb begin
    for (int m = 0; m < NXM; m++) begin
      xm_gnt[m] = xb_busy[NXS] && (xb_owner[NXS] == MW'(m)) && bridge_on_bus;
      for (int d = 0; d < NXS; d++)
        if (xb_busy[d] && (xb_owner[d] == MW'(m))) xm_gnt[m] = 1'b1;
    end
    for (int i = 0; i < NB; i++)
      bm_gnt[i] = bus_busy && (bus_owner == BRW'(i));
    for (int d = 0; d < NXS; d++) begin
      xs_valid[d]          = xb_busy[d];
      xs_src[d*MW +: MW]   = xb_owner[d];
      xs_data[d*DW +: DW]  = xm_wdata[int'(xb_owner[d])*DW +: DW];
    end
    bus_valid = bus_busy;
    bus_sel   = '0;
    bus_data  = '0;
    if (bridge_on_bus) begin
      bus_sel  = BSW'(int'(xm_tgt[int'(xb_owner[NXS])*TW +: TW]) - NXS);
      bus_data = xm_wdata[int'(xb_owner[NXS])*DW +: DW];
    end else if (bus_busy) begin
      bus_sel  = BSW'(int'(bm_tgt[int'(bus_owner)*TW +: TW]) - NXS);
      bus_data = bm_wdata[int'(bus_owner)*DW +: DW];
    end
  end

  // sticky target errors
  always_ff @(posedge clk) begin
    if (rst) begin
      xm_err <= '0;
      bm_err <= '0;
    end else begin
      xm_err <= (xm_err & ~xm_err_clr) | (xm_req & ~xm_ok);
      bm_err <= (bm_err & ~bm_err_clr) | (bm_req & ~bm_ok);
    end
  end

  p_bridge_bus_r7: assert property (@(posedge clk) disable iff (rst)
    bridge_on_bus |-> xb_busy[NXS]);

  for (genvar m = 0; m < NXM; m++) begin : g_chk
    p_bad_nogrant_r9: assert property (@(posedge clk) disable iff (rst)
      (xm_req[m] && !xm_ok[m] && !xm_gnt[m]) |=> !xm_gnt[m]);
    p_err_set_r9: assert property (@(posedge clk) disable iff (rst)
      (xm_req[m] && !xm_ok[m]) |=> xm_err[m]);
  end
endmodule

// File: tb/sim_hxb_top.sv
module sim_hxb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NXM = 3, NXS = 2, NB = 3, DW = 8, TW = 3, MW = 2, BSW = 2;
  localparam int BOUND = 200;

  logic clk = 1'b0, rst = 1'b1;
  logic [NXM-1:0] xm_req = '0, xm_done = '0, xm_err_clr = '0, xm_gnt, xm_err;
  logic [NXM*TW-1:0] xm_tgt = '0;
  logic [NXM*DW-1:0] xm_wdata = '0;
  logic [NB-1:0] bm_req = '0, bm_done = '0, bm_err_clr = '0, bm_gnt, bm_err;
  logic [NB*TW-1:0] bm_tgt = '0;
  logic [NB*DW-1:0] bm_wdata = '0;
  logic [NXS-1:0] xs_valid;
  logic [NXS*MW-1:0] xs_src;
  logic [NXS*DW-1:0] xs_data;
  logic bus_valid;
  logic [BSW-1:0] bus_sel;
  logic [DW-1:0] bus_data;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hxb_top #(.NXM(NXM), .NXS(NXS), .NB(NB), .DW(DW), .TW(TW)) u0 (
    .clk(clk), .rst(rst),
    .xm_req(xm_req), .xm_tgt(xm_tgt), .xm_wdata(xm_wdata), .xm_done(xm_done),
    .xm_err_clr(xm_err_clr), .xm_gnt(xm_gnt), .xm_err(xm_err),
    .bm_req(bm_req), .bm_tgt(bm_tgt), .bm_wdata(bm_wdata), .bm_done(bm_done),
    .bm_err_clr(bm_err_clr), .bm_gnt(bm_gnt), .bm_err(bm_err),
    .xs_valid(xs_valid), .xs_src(xs_src), .xs_data(xs_data),
    .bus_valid(bus_valid), .bus_sel(bus_sel), .bus_data(bus_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic xset(input int m, input bit r, input int t, input int dat);
    xm_req[m] = r;
    xm_tgt[m*TW +: TW] = TW'(t);
    xm_wdata[m*DW +: DW] = DW'(dat);
  endtask

  task automatic bset(input int i, input bit r, input int t, input int dat);
    bm_req[i] = r;
    bm_tgt[i*TW +: TW] = TW'(t);
    bm_wdata[i*DW +: DW] = DW'(dat);
  endtask

  // finish a crossbar master: pulse done and drop request
  task automatic xfin(input logic [NXM-1:0] mask);
    xm_done = mask;
    xm_req = xm_req & ~mask;
    tick();
    xm_done = '0;
  endtask

  task automatic bfin(input logic [NB-1:0] mask);
    bm_done = mask;
    bm_req = bm_req & ~mask;
    tick();
    bm_done = '0;
  endtask

  task automatic t_reset();
    check(xm_gnt == 0 && bm_gnt == 0, "R1 grants", {xm_gnt, bm_gnt}, 0);
    check(xs_valid == 0 && !bus_valid, "R1 valids", {xs_valid, bus_valid}, 0);
    check(xm_err == 0 && bm_err == 0, "R1 errors", {xm_err, bm_err}, 0);
  endtask

  task automatic t_parallel();
    xset(0, 1, 0, 8'hA0);
    xset(1, 1, 1, 8'hA1);
    tick();
    check(xm_gnt == 3'b011, "R2 parallel grants", xm_gnt, 3);
    check(xs_valid == 2'b11, "R2 outputs valid", xs_valid, 3);
    check(xs_src == {2'd1, 2'd0}, "R10 xs_src", xs_src, 4);
    check(xs_data == {8'hA1, 8'hA0}, "R10 xs_data", xs_data, 16'hA1A0);
    xfin(3'b011);
    check(xm_gnt == 0 && xs_valid == 0, "R4 released", xm_gnt, 0);
  endtask

  // output 0 pointer is now 1 after master 0 released it
  task automatic t_conflict();
    xset(0, 1, 0, 8'h10);
    xset(1, 1, 0, 8'h11);
    xset(2, 1, 0, 8'h12);
    tick();
    check(xm_gnt == 3'b010, "R3 rr winner m1", xm_gnt, 2);
    tick(); tick();
    check(xm_gnt == 3'b010, "R4 path held", xm_gnt, 2);
    check(xs_src[1:0] == 2'd1 && xs_data[7:0] == 8'h11, "R10 owner data", xs_data[7:0], 8'h11);
    xfin(3'b010);
    check(xm_gnt == 0, "R4 gap after done", xm_gnt, 0);
    tick();
    check(xm_gnt == 3'b100, "R3 rr next m2", xm_gnt, 4);
    xfin(3'b100);
    check(xm_gnt == 0, "R4 gap after done", xm_gnt, 0);
    tick();
    check(xm_gnt == 3'b001, "R3 rr wrap m0", xm_gnt, 1);
    xfin(3'b001);
    tick();
  endtask

  task automatic t_bus();
    bset(0, 1, 3, 8'hB0);
    bset(1, 1, 4, 8'hB1);
    bset(2, 1, 2, 8'hB2);
    tick();
    check(bm_gnt == 3'b001, "R5 bus first b0", bm_gnt, 1);
    check(bus_sel == 1 && bus_data == 8'hB0, "R10 bus path b0", bus_sel, 1);
    bfin(3'b001);
    check(bm_gnt == 0 && !bus_valid, "R5 bus idle gap", bm_gnt, 0);
    tick();
    check(bm_gnt == 3'b010 && bus_sel == 2, "R5 bus next b1", bm_gnt, 2);
    bfin(3'b010);
    tick();
    check(bm_gnt == 3'b100 && bus_sel == 0 && bus_data == 8'hB2, "R5 bus next b2", bm_gnt, 4);
    bfin(3'b100);
    tick();
  endtask

  task automatic t_bridge();
    xset(2, 1, 4, 8'hC2);
    tick();
    check(xm_gnt == 0, "R7 not yet after one clock", xm_gnt, 0);
    tick();
    check(xm_gnt == 3'b100 && bus_valid, "R7 grant after two clocks", xm_gnt, 4);
    check(bus_sel == 2 && bus_data == 8'hC2 && bm_gnt == 0, "R8 bridge to bus IP2", bus_sel, 2);
    check(xs_valid == 0, "R7 bridge hidden", xs_valid, 0);
    xfin(3'b100);
    tick();
    bset(0, 1, 2, 8'hB5);
    tick();
    check(bm_gnt == 3'b001, "R5 b0 owns bus", bm_gnt, 1);
    xset(0, 1, 3, 8'hC0);
    xset(1, 1, 1, 8'hC1);
    tick();
    check(xm_gnt == 3'b010, "R6 xbar runs while bus busy", xm_gnt, 2);
    tick();
    check(xm_gnt[0] == 0 && bm_gnt == 3'b001, "R7 bridge waits for bus", xm_gnt, 2);
    bfin(3'b001);
    check(xm_gnt == 3'b010 && !bus_valid, "R4 bus free gap", xm_gnt, 2);
    tick();
    check(xm_gnt == 3'b011 && bus_sel == 1 && bus_data == 8'hC0, "R7 bridge takes bus", xm_gnt, 3);
    xfin(3'b011);
    tick();
  endtask

  task automatic t_error();
    xset(2, 1, 7, 8'hEE);
    bset(1, 1, 0, 8'hEF);
    tick();
    check(xm_err[2] && bm_err[1], "R9 error set", {xm_err, bm_err}, 6'b100010);
    check(xm_gnt == 0 && bm_gnt == 0, "R8 bad targets not granted", {xm_gnt, bm_gnt}, 0);
    tick(); tick();
    check(xm_gnt == 0 && bm_gnt == 0 && !bus_valid && xs_valid == 0, "R9 never granted", xm_gnt, 0);
    xm_req = '0;
    bm_req = '0;
    tick();
    check(xm_err[2] && bm_err[1], "R9 sticky", {xm_err, bm_err}, 6'b100010);
    xm_err_clr = 3'b100;
    bm_err_clr = 3'b010;
    tick();
    xm_err_clr = '0;
    bm_err_clr = '0;
    check(xm_err == 0 && bm_err == 0, "R9 cleared", {xm_err, bm_err}, 0);
  endtask

  // pseudo-random traffic with exclusivity and wait-bound monitors
  bit xa[NXM], ba[NB];
  int xt[NXM], bt[NB], xh[NXM], bh[NB], xw[NXM], bw[NB];
  int viol = 0, maxw = 0;

  task automatic t_stress(input int cycles, input bit allow_new);
    for (int c = 0; c < cycles; c++) begin
      tick();
      for (int d = 0; d < NXS; d++) begin
        int cnt = 0;
        for (int m = 0; m < NXM; m++)
          if (xm_gnt[m] && xt[m] == d) begin
            cnt++;
            if (int'(xs_src[d*MW +: MW]) != m) viol++;
          end
        if (cnt > 1) viol++;
      end
      begin
        int bc = $countones(bm_gnt);
        for (int m = 0; m < NXM; m++) if (xm_gnt[m] && xt[m] >= NXS) bc++;
        if (bc > 1) viol++;
      end
      xm_done = '0;
      bm_done = '0;
      for (int m = 0; m < NXM; m++) begin
        if (!xa[m]) begin
          if (allow_new && $urandom_range(0, 3) == 0) begin
            xa[m] = 1; xt[m] = $urandom_range(0, 4); xh[m] = $urandom_range(0, 2); xw[m] = 0;
            xset(m, 1, xt[m], $urandom_range(0, 255));
          end
        end else if (xm_gnt[m]) begin
          if (xh[m] == 0) begin xm_done[m] = 1; xm_req[m] = 0; xa[m] = 0; end
          else xh[m]--;
        end else begin
          xw[m]++;
          if (xw[m] > maxw) maxw = xw[m];
        end
      end
      for (int i = 0; i < NB; i++) begin
        if (!ba[i]) begin
          if (allow_new && $urandom_range(0, 3) == 0) begin
            ba[i] = 1; bt[i] = $urandom_range(2, 4); bh[i] = $urandom_range(0, 2); bw[i] = 0;
            bset(i, 1, bt[i], $urandom_range(0, 255));
          end
        end else if (bm_gnt[i]) begin
          if (bh[i] == 0) begin bm_done[i] = 1; bm_req[i] = 0; ba[i] = 0; end
          else bh[i]--;
        end else begin
          bw[i]++;
          if (bw[i] > maxw) maxw = bw[i];
        end
      end
    end
    tick();
    xm_done = '0;
    bm_done = '0;
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_parallel();
    t_conflict();
    t_bus();
    t_bridge();
    t_error();
    t_stress(3000, 1'b1);
    t_stress(300, 1'b0);
    repeat (3) tick();
    check(viol == 0, "R5 R3 exclusive owners under traffic", viol, 0);
    check(maxw <= BOUND, "R3 bounded wait", maxw, BOUND);
    check(xm_gnt == 0 && bm_gnt == 0 && xm_err == 0 && bm_err == 0, "R4 all released", {xm_gnt, bm_gnt}, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule